// File: doc/BRIEF.md
# Tributary Alarm Change Latch Bank

This block watches seven live alarm levels coming from per-tributary defect detectors (for example loss of clock or an all-ones alarm on each of seven lower-rate tributaries). It records, in one sticky bit per tributary, that the level has changed since software last looked. A change in either direction counts. Software can therefore detect both the start and the end of an alarm by polling a single 16-bit register.

Software reaches the register over a simple strobe bus: a read strobe, a write strobe with 16-bit write data, and a read data bus. The sticky bits appear in register bits 6:0. Register bit k-1 belongs to tributary k, which is `status_i[k-1]`. A run-time mode input selects how software acknowledges the bits. In clear-on-read mode, a read clears everything it returned. In clear-on-write mode, software writes ones to the bits it wants cleared.

A change in the same cycle as a clear always leaves the bit set, so no event is lost. Each change is detected against a registered copy of the status, so one level change gives exactly one set event.

Top module: `alarm_delta_bank`

## Requirements
- R1: After reset, `rdata_o` reads 0x0000.
- R2: When `status_i[n]` goes from 0 to 1, `rdata_o[n]` reads 1 from the clock edge that samples the new level onward, until it is cleared.
- R3: When `status_i[n]` goes from 1 to 0, `rdata_o[n]` is set with the same timing as in R2.
- R4: `rdata_o[15:7]` always reads zero. `wdata_i[15:7]` has no effect.
- R5: With `cow_mode_i`=0 (clear-on-read), a clock edge that samples `rd_i`=1 clears every bit returned in that cycle. The result is visible from the next cycle.
- R6: With `cow_mode_i`=1 (clear-on-write), a clock edge that samples `wr_i`=1 clears each bit n where `wdata_i[n]`=1. Bits where `wdata_i[n]`=0 keep their value.
- R7: `rd_i` has no effect when `cow_mode_i`=1. `wr_i` has no effect when `cow_mode_i`=0.
- R8: A status change sampled at the same edge as a clear of that bit leaves the bit set.
- R9: A cleared bit stays 0 until its status bit changes again. A held status level causes no further sets.
- R10: The status level present at the first clock edge after reset is taken as the baseline and sets no bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| status_i | input | 7 | Live alarm levels; bit n is tributary n+1 |
| cow_mode_i | input | 1 | 0 = clear-on-read, 1 = clear-on-write |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 16 | Write data; ones mark bits to clear in write mode |
| rdata_o | output | 16 | Change register; bits 6:0 are the sticky change flags |

## Verification
Several properties are checked on every cycle:
- the reserved bits always read zero;
- a sampled status change always sets its bit on the next cycle;
- no bit rises without a preceding change;
- register contents hold when there is neither a change nor a valid clear;
- each acknowledge mode clears exactly what it should, and the strobe of the other mode does nothing.

Other behaviour can only be shown by the bench's scenarios:
- the baseline taken from the first sample after reset;
- collisions between a change and a clear on the same bit;
- switching the acknowledge mode while bits are pending;
- a long mixed sequence of status changes and acknowledges, compared against a reference model.

// File: rtl/alarm_delta_pkg.sv
package alarm_delta_pkg;
  parameter int unsigned ADB_STATUS_W = 7;
  parameter int unsigned ADB_REG_W    = 16;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    CLR_ON_WRITE = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/adb_change_detect.sv
module adb_change_detect #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] level_i,
  output logic [W-1:0] change_o
);
  logic [W-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= level_i;
      armed_q <= 1'b1;
    end
  end

  // first sample after reset only establishes the baseline
  assign change_o = armed_q ? (level_i ^ prev_q) : '0;
endmodule

// File: rtl/adb_clear_sel.sv
module adb_clear_sel
  import alarm_delta_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  clr_mode_e    mode_i,
  input  logic         rd_i,
  input  logic         wr_i,
  input  logic [W-1:0] wmask_i,
  output logic [W-1:0] clear_o
);
  always_comb begin
    unique case (mode_i)
      CLR_ON_READ:  clear_o = rd_i ? '1 : '0;
      CLR_ON_WRITE: clear_o = wr_i ? wmask_i : '0;
      default:      clear_o = '0;
    endcase
  end
endmodule

// File: rtl/adb_delta_latch.sv
module adb_delta_latch #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clear_i,
  output logic [W-1:0] delta_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q <= 1'b0;
      else if (set_i[i])  bit_q <= 1'b1;  // set beats clear
      else if (clear_i[i]) bit_q <= 1'b0;
    end
    assign delta_o[i] = bit_q;
  end
endmodule

// File: rtl/alarm_delta_bank.sv
module alarm_delta_bank
  import alarm_delta_pkg::*;
#(
  parameter int unsigned STATUS_W = ADB_STATUS_W,
  parameter int unsigned REG_W    = ADB_REG_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                cow_mode_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o
);
  localparam int unsigned RSVD_W = REG_W - STATUS_W;

  logic [STATUS_W-1:0] change;
  logic [STATUS_W-1:0] clear;
  logic [STATUS_W-1:0] delta;
  clr_mode_e           mode;
  logic                unused_wdata;

  assign mode         = clr_mode_e'(cow_mode_i);
  assign unused_wdata = ^wdata_i[REG_W-1:STATUS_W];

  adb_change_detect #(.W(STATUS_W)) u_detect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .level_i  (status_i),
    .change_o (change)
  );

  adb_clear_sel #(.W(STATUS_W)) u_clear (
    .mode_i  (mode),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wmask_i (wdata_i[STATUS_W-1:0]),
    .clear_o (clear)
  );

  adb_delta_latch #(.W(STATUS_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (change),
    .clear_i (clear),
    .delta_o (delta)
  );

  assign rdata_o = {{RSVD_W{1'b0}}, delta};
endmodule

// File: rtl/alarm_delta_bank_chk.sv
module alarm_delta_bank_chk #(
  parameter int unsigned STATUS_W = 7,
  parameter int unsigned REG_W    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [STATUS_W-1:0] status_i,
  input logic                cow_mode_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [REG_W-1:0]    wdata_i,
  input logic [REG_W-1:0]    rdata_o
);
  logic [STATUS_W-1:0] chk_prev;
  logic                chk_seen;
  logic [STATUS_W-1:0] chg;
  logic [STATUS_W-1:0] flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_prev <= '0;
      chk_seen <= 1'b0;
    end else begin
      chk_prev <= status_i;
      chk_seen <= 1'b1;
    end
  end

  assign chg   = chk_seen ? (status_i ^ chk_prev) : '0;
  assign flags = rdata_o[STATUS_W-1:0];

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[REG_W-1:STATUS_W] == '0);  // R4

  AST_CHANGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((flags & $past(chg)) == $past(chg)));  // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(chg)) == '0));  // R9

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i && chg == '0) |=> $stable(rdata_o));  // R9

  AST_COR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cow_mode_i && rd_i && chg == '0) |=> (flags == '0));  // R5

  AST_COW_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cow_mode_i && wr_i && chg == '0) |=>
      ((flags & $past(wdata_i[STATUS_W-1:0])) == '0) &&
      ((flags & ~$past(wdata_i[STATUS_W-1:0])) ==
       ($past(flags) & ~$past(wdata_i[STATUS_W-1:0]))));  // R6

  AST_COW_READ_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cow_mode_i && rd_i && !wr_i && chg == '0) |=> $stable(rdata_o));  // R7

  AST_COR_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cow_mode_i && wr_i && !rd_i && chg == '0) |=> $stable(rdata_o));  // R7
endmodule

bind alarm_delta_bank alarm_delta_bank_chk #(
  .STATUS_W (STATUS_W),
  .REG_W    (REG_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .status_i   (status_i),
  .cow_mode_i (cow_mode_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o)
);

// File: tb/tb_alarm_delta_bank.sv
module tb_alarm_delta_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  status_i = '0;
  logic        cow_mode_i = 1'b0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  // reference state built from the requirements
  logic [6:0] m_prev;
  logic       m_armed;
  logic [6:0] m_flags;

  always #2.5 clk_i = ~clk_i;

  alarm_delta_bank dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .status_i   (status_i),
    .cow_mode_i (cow_mode_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rdata_o=%h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle, then queue the expected register value
  task automatic step(input logic [6:0] st, input logic cow, input logic rd,
                      input logic wr, input logic [15:0] wd, input string tag);
    logic [6:0] chg, clr;
    @(negedge clk_i);
    status_i = st; cow_mode_i = cow; rd_i = rd; wr_i = wr; wdata_i = wd;
    @(posedge clk_i);
    chg = m_armed ? (st ^ m_prev) : 7'h00;
    if (cow) clr = wr ? wd[6:0] : 7'h00;
    else     clr = rd ? 7'h7f : 7'h00;
    m_flags = chg | (m_flags & ~clr);
    m_prev  = st;
    m_armed = 1'b1;
    sb_q.push_back('{exp: {9'h000, m_flags}, tag: tag});
  endtask

  // monitor: compare queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk_i);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(rdata_o, it.exp, it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: rdata_o=%h expected completion", rdata_o);
    finish_run();
  end

  initial begin
    m_prev = '0; m_armed = 1'b0; m_flags = '0;
    status_i = 7'h05;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(rdata_o, 16'h0000, "R1 reset value");
    rst_ni = 1'b1;

    step(7'h05, 1'b0, 1'b0, 1'b0, 16'h0000, "R10 baseline level");
    step(7'h07, 1'b0, 1'b0, 1'b0, 16'h0000, "R2 rise on bit1");
    step(7'h07, 1'b0, 1'b0, 1'b0, 16'h0000, "R9 held level");
    step(7'h03, 1'b0, 1'b0, 1'b0, 16'h0000, "R3 fall on bit2");
    step(7'h03, 1'b0, 1'b0, 1'b1, 16'hffff, "R7 write ignored in read mode, R4");
    step(7'h03, 1'b0, 1'b1, 1'b0, 16'h0000, "R5 read clears");
    step(7'h03, 1'b0, 1'b0, 1'b0, 16'h0000, "R9 stays clear");
    step(7'h01, 1'b0, 1'b1, 1'b0, 16'h0000, "R8 change beats read clear");
    step(7'h01, 1'b1, 1'b0, 1'b0, 16'h0000, "R6 mode switch keeps bits");
    step(7'h01, 1'b1, 1'b1, 1'b0, 16'h0000, "R7 read ignored in write mode");
    step(7'h41, 1'b1, 1'b0, 1'b1, 16'h0002, "R6 write one clears bit1");
    step(7'h41, 1'b1, 1'b0, 1'b1, 16'h0000, "R6 write zero keeps");
    step(7'h40, 1'b1, 1'b0, 1'b1, 16'h0001, "R8 change beats write clear");
    step(7'h40, 1'b1, 1'b0, 1'b1, 16'hff80, "R4 reserved write bits inert");
    step(7'h40, 1'b1, 1'b0, 1'b1, 16'hffff, "R6 clear all");
    step(7'h40, 1'b1, 1'b0, 1'b0, 16'h0000, "R9 no re-set");

    for (int i = 0; i < 60; i++) begin
      logic [6:0] st;
      logic [3:0] r;
      st = ((i % 3) == 0) ? status_i : 7'($urandom);
      r  = 4'($urandom);
      step(st, r[0], r[1], r[2], 16'($urandom), "R2 mixed traffic");
    end

    @(negedge clk_i);
    @(negedge clk_i);
    finish_run();
  end
endmodule